// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver with Hunt and Station-Address Filter

This block sits behind a serial line sampler. It takes one received bit per asserted bit strobe and finds the frame delimiters in the stream. It strips the zeros that the sender inserted for transparency and packs the remaining bits into bytes, least significant bit first. Each byte is offered to a downstream receive queue as a one-cycle write strobe, together with an end-of-frame marker and a frame-check error bit.

While hunting, the receiver writes nothing. It leaves the hunt on an opening delimiter. The first byte after that delimiter is the station address. Optionally, the receiver accepts only frames whose address matches a programmed value or the all-ones broadcast value. The match can cover the full byte or only its upper four bits.

A 16-bit frame check runs over every byte between the delimiters, whatever the settings are. The two check bytes are held back and never written to the queue. A line abort, a disable or an explicit hunt command puts the receiver back into the hunt.

Top module: `sdlc_rx_hunt`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `rx_enable` low, `hunt_status` is 1 and `wr_valid` is 0. While disabled, incoming bits are ignored.
- R2: While hunting, no byte is written. The opening delimiter (bits 0,1,1,1,1,1,1,0 in line order, value 0x7E) ends the hunt, and `hunt_status` reads 0 from the cycle after its last bit.
- R3: A 0 bit that follows five consecutive 1 bits is removed from the data. Bytes are assembled with the first received bit as bit 0, so data bytes that contain 0x7E or long runs of 1s are delivered unchanged.
- R4: Seven consecutive 1 bits (abort) put the receiver into the hunt. `hunt_status` is 1 on the next cycle. Bytes still held back are dropped and no end-of-frame is written.
- R5: With `addr_search_en` low, every non-check byte of a frame is written in order, the address byte first.
- R6: With `addr_search_en` high, a frame is written only if its first byte equals `station_addr` or equals 0xFF. Otherwise nothing of the frame is written, and `hunt_status` is 1 from the cycle after the address byte.
- R7: With `addr_search_en` and `addr_nibble_only` both high, only bits 7:4 of the address byte must equal bits 7:4 of `station_addr`. The full address byte is still written as data.
- R8: The last two bytes before the closing delimiter are check bytes and are never written. The last data byte is written in the cycle after the closing delimiter's last bit, with `wr_eof` = 1. All other bytes carry `wr_eof` = 0 and `wr_crc_err` = 0.
- R9: The frame check uses a 16-bit register preset to all ones, polynomial x^16+x^12+x^5+1, and least significant bit first. A check that is sent inverted, low byte first, leaves 0xF0B8. `wr_crc_err` on the end-of-frame byte is 0 exactly when that residue is present.
- R10: A frame that closes with only one or two bytes writes its oldest byte with `wr_eof` = 1 and `wr_crc_err` = 1.
- R11: A `hunt_cmd` pulse puts the receiver into the hunt on the next cycle. Bytes of the frame in progress that are still held back are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Qualifies `rx_bit` for one cycle per line bit |
| rx_bit | input | 1 | Received line bit |
| rx_enable | input | 1 | Receiver enable; low forces the hunt |
| hunt_cmd | input | 1 | One-cycle command to re-enter the hunt |
| addr_search_en | input | 1 | Enables station-address filtering |
| addr_nibble_only | input | 1 | Address compare limited to bits 7:4 |
| station_addr | input | 8 | Programmed station address |
| wr_valid | output | 1 | Write strobe toward the receive queue |
| wr_data | output | 8 | Byte being written |
| wr_eof | output | 1 | Byte is the last of its frame |
| wr_crc_err | output | 1 | Frame check failed; meaningful with `wr_eof` |
| hunt_status | output | 1 | 1 while the receiver is hunting |

## Verification
A corrupted run-length count of 1s shows up within one byte time: a byte comes out shifted, or a delimiter or abort is missed. A wrong hunt or address state is visible on the next `hunt_status` sample, or as a missing or extra write strobe. Because the write of each byte waits for three further bytes, a fault in the hold-back pipeline shows only when a frame closes. That fault shows as a wrong byte carrying the end-of-frame marker, or as a check byte leaking out. A fault in the check register is seen only in `wr_crc_err` at frame end.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;

  localparam int BYTE_W = 8;
  localparam logic [15:0] FCS_POLY_REFL = 16'h8408;
  localparam logic [15:0] FCS_PRESET    = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE   = 16'hF0B8;
  localparam logic [BYTE_W-1:0] ADDR_BROADCAST = 8'hFF;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_FRAME = 2'd2
  } rx_state_e;

  // One byte through the reflected CCITT check, bit 0 first.
  function automatic logic [15:0] fcs_next(input logic [15:0] cur,
                                           input logic [BYTE_W-1:0] din);
    logic [15:0] r;
    r = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ din[i]) r = (r >> 1) ^ FCS_POLY_REFL;
      else               r = r >> 1;
    end
    return r;
  endfunction

  // Station address acceptance.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [BYTE_W-1:0] own,
                                    input logic nibble_only);
    if (rx == ADDR_BROADCAST) return 1'b1;
    if (nibble_only)          return rx[BYTE_W-1:BYTE_W/2] == own[BYTE_W-1:BYTE_W/2];
    return rx == own;
  endfunction

endpackage

// File: rtl/sdlc_bit_deframer.sv
module sdlc_bit_deframer #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_en,
  input  logic rx_bit,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_data,
  output logic data_bit
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_CAP = STUFF_RUN + 2;
  localparam int RUN_W     = $clog2(ABORT_CAP + 1);

  logic [RUN_W-1:0] ones_q;

  // Classify the current line bit against the run of 1s before it.
  always_comb begin
    ev_flag  = 1'b0;
    ev_abort = 1'b0;
    ev_data  = 1'b0;
    data_bit = rx_bit;
    if (enable && bit_en) begin
      if (rx_bit) begin
        if (ones_q == RUN_W'(FLAG_RUN))     ev_abort = 1'b1;
        else if (ones_q < RUN_W'(FLAG_RUN)) ev_data  = 1'b1;
      end else begin
        if (ones_q == RUN_W'(FLAG_RUN))          ev_flag = 1'b1;
        else if (ones_q != RUN_W'(STUFF_RUN))    ev_data = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ones_q <= '0;
    else if (!enable)         ones_q <= '0;
    else if (bit_en) begin
      if (!rx_bit)                           ones_q <= '0;
      else if (ones_q != RUN_W'(ABORT_CAP))  ones_q <= ones_q + RUN_W'(1);
    end
  end

  // R3: any delimiter leaves the run counter cleared
  p_flag_clears_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag |=> (ones_q == '0));

  // R4: an abort is reported only when the run has reached its cap
  p_abort_caps_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (ones_q == RUN_W'(ABORT_CAP)));

endmodule

// File: rtl/sdlc_fcs_check.sv
module sdlc_fcs_check
  import sdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [15:0]       fcs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fcs_q <= FCS_PRESET;
    else if (clear) fcs_q <= FCS_PRESET;
    else if (upd)   fcs_q <= fcs_next(fcs_q, din);
  end

  // R9: each frame's check starts from the preset value
  p_preset_on_delim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fcs_q == FCS_PRESET));

  // R9: the check register never changes without a byte or a delimiter
  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !upd) |=> $stable(fcs_q));

endmodule

// File: rtl/sdlc_frame_ctrl.sv
module sdlc_frame_ctrl
  import sdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              hunt_cmd,
  input  logic              addr_search_en,
  input  logic              addr_nibble_only,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic              ev_flag,
  input  logic              ev_abort,
  input  logic              ev_data,
  input  logic              data_bit,
  input  logic [15:0]       fcs_q,
  output logic              fcs_clear,
  output logic              fcs_upd,
  output logic [BYTE_W-1:0] fcs_byte,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_eof,
  output logic              wr_crc_err,
  output logic              hunt_status
);
  localparam int HOLD  = FCS_BYTES + 1;
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam int BIT_W = $clog2(BYTE_W);

  rx_state_e         state_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BIT_W-1:0]  bitcnt_q;
  logic [CNT_W-1:0]  nbytes_q;
  logic [BYTE_W-1:0] hold_q [HOLD];

  logic              force_hunt;
  logic              byte_done;
  logic [BYTE_W-1:0] new_byte;
  logic              addr_ok;
  logic              push;
  logic              pipe_full;
  logic [BYTE_W-1:0] oldest;

  assign force_hunt = !rx_enable || hunt_cmd;
  assign new_byte   = {data_bit, sh_q[BYTE_W-1:1]};
  assign byte_done  = ev_data && (state_q != ST_HUNT) && (bitcnt_q == BIT_W'(BYTE_W - 1));
  assign addr_ok    = !addr_search_en || addr_hit(new_byte, station_addr, addr_nibble_only);
  assign pipe_full  = (nbytes_q == CNT_W'(HOLD));
  assign push       = !force_hunt && byte_done &&
                      (state_q == ST_FRAME || (state_q == ST_ADDR && addr_ok));

  assign fcs_clear   = ev_flag;
  assign fcs_upd     = byte_done;
  assign fcs_byte    = new_byte;
  assign hunt_status = (state_q == ST_HUNT);

  // Oldest byte still held back.
  always_comb begin
    oldest = hold_q[0];
    for (int i = 0; i < HOLD; i++)
      if (nbytes_q == CNT_W'(i + 1)) oldest = hold_q[i];
  end

  // Hold-back shift chain: slot 0 newest.
  for (genvar g = 0; g < HOLD; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q[g] <= '0;
      else if (push) begin
        if (g == 0) hold_q[g] <= new_byte;
        else        hold_q[g] <= hold_q[(g == 0) ? 0 : g - 1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      sh_q       <= '0;
      bitcnt_q   <= '0;
      nbytes_q   <= '0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_eof     <= 1'b0;
      wr_crc_err <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (force_hunt || ev_abort) begin
        state_q  <= ST_HUNT;
        nbytes_q <= '0;
      end else if (ev_flag) begin
        if (state_q == ST_FRAME && nbytes_q != '0) begin
          wr_valid   <= 1'b1;
          wr_data    <= oldest;
          wr_eof     <= 1'b1;
          wr_crc_err <= !pipe_full || (fcs_q != FCS_RESIDUE);
        end
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        nbytes_q <= '0;
      end else if (ev_data && state_q != ST_HUNT) begin
        sh_q     <= new_byte;
        bitcnt_q <= bitcnt_q + BIT_W'(1);
        if (byte_done) begin
          if (state_q == ST_ADDR) begin
            if (addr_ok) begin
              state_q  <= ST_FRAME;
              nbytes_q <= CNT_W'(1);
            end else begin
              state_q  <= ST_HUNT;
            end
          end else if (pipe_full) begin
            wr_valid   <= 1'b1;
            wr_data    <= hold_q[HOLD-1];
            wr_eof     <= 1'b0;
            wr_crc_err <= 1'b0;
          end else begin
            nbytes_q <= nbytes_q + CNT_W'(1);
          end
        end
      end
    end
  end

  // R2: nothing is written out of the hunt
  p_no_write_hunting_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(state_q) != ST_HUNT));

  // R8: end of frame only follows a delimiter
  p_eof_after_delim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_eof) |-> $past(ev_flag));

  // R8: a non-final byte never carries an error
  p_mid_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_eof) |-> !wr_crc_err);

  // R4: abort lands in the hunt without a write
  p_abort_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && ev_abort) |=> (hunt_status && !wr_valid));

  // R1: disable holds the hunt and silences writes
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (hunt_status && !wr_valid));

  // R11: the hunt command takes effect on the next cycle
  p_hunt_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cmd |=> hunt_status);

  // R10: a frame too short for its check is flagged
  p_short_flagged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_eof && ($past(nbytes_q) != CNT_W'(HOLD))) |-> wr_crc_err);

endmodule

// File: rtl/sdlc_rx_hunt.sv
module sdlc_rx_hunt
  import sdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES = 2,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              rx_enable,
  input  logic              hunt_cmd,
  input  logic              addr_search_en,
  input  logic              addr_nibble_only,
  input  logic [BYTE_W-1:0] station_addr,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_eof,
  output logic              wr_crc_err,
  output logic              hunt_status
);
  logic              ev_flag, ev_abort, ev_data, data_bit;
  logic              fcs_clear, fcs_upd;
  logic [BYTE_W-1:0] fcs_byte;
  logic [15:0]       fcs_q;

  sdlc_bit_deframer #(.STUFF_RUN(STUFF_RUN)) u_deframe (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (rx_enable),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .ev_flag  (ev_flag),
    .ev_abort (ev_abort),
    .ev_data  (ev_data),
    .data_bit (data_bit)
  );

  sdlc_fcs_check u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fcs_clear),
    .upd   (fcs_upd),
    .din   (fcs_byte),
    .fcs_q (fcs_q)
  );

  sdlc_frame_ctrl #(.FCS_BYTES(FCS_BYTES)) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_enable        (rx_enable),
    .hunt_cmd         (hunt_cmd),
    .addr_search_en   (addr_search_en),
    .addr_nibble_only (addr_nibble_only),
    .station_addr     (station_addr),
    .ev_flag          (ev_flag),
    .ev_abort         (ev_abort),
    .ev_data          (ev_data),
    .data_bit         (data_bit),
    .fcs_q            (fcs_q),
    .fcs_clear        (fcs_clear),
    .fcs_upd          (fcs_upd),
    .fcs_byte         (fcs_byte),
    .wr_valid         (wr_valid),
    .wr_data          (wr_data),
    .wr_eof           (wr_eof),
    .wr_crc_err       (wr_crc_err),
    .hunt_status      (hunt_status)
  );

endmodule

// File: tb/sdlc_rx_hunt_tb_top.sv
module sdlc_rx_hunt_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       rx_bit = 1'b1;
  logic       rx_enable = 1'b0;
  logic       hunt_cmd = 1'b0;
  logic       addr_search_en = 1'b0;
  logic       addr_nibble_only = 1'b0;
  logic [7:0] station_addr = 8'h00;
  logic       wr_valid, wr_eof, wr_crc_err, hunt_status;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  sdlc_rx_hunt dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .rx_enable(rx_enable), .hunt_cmd(hunt_cmd),
    .addr_search_en(addr_search_en), .addr_nibble_only(addr_nibble_only),
    .station_addr(station_addr), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_eof(wr_eof), .wr_crc_err(wr_crc_err), .hunt_status(hunt_status)
  );

  typedef struct {
    logic [7:0] d;
    logic       eof;
    logic       err;
    string      tag;
  } exp_t;

  exp_t expq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   run   = 0;
  bit   done  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pop and compare each written byte.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2/R6", "unexpected write", {22'd0, wr_eof, wr_crc_err, wr_data}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(wr_data === e.d && wr_eof === e.eof && wr_crc_err === e.err, e.tag,
              "byte/eof/err", {22'd0, wr_eof, wr_crc_err, wr_data}, {22'd0, e.eof, e.err, e.d});
      end
    end
  end

  task automatic line_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_delim();
    logic [7:0] f;
    f = 8'h7E;
    for (int i = 0; i < 8; i++) line_bit(f[i]);
    run = 0;
  endtask

  task automatic send_abort();
    for (int i = 0; i < 8; i++) line_bit(1'b1);
    run = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      line_bit(b[i]);
      if (b[i]) begin
        run++;
        if (run == 5) begin
          line_bit(1'b0);
          run = 0;
        end
      end else begin
        run = 0;
      end
    end
  endtask

  function automatic logic [15:0] tb_fcs(input logic [7:0] body[$]);
    logic [15:0] c;
    logic        x;
    c = 16'hFFFF;
    foreach (body[k]) begin
      for (int j = 0; j < 8; j++) begin
        x = c[0] ^ body[k][j];
        c = {1'b0, c[15:1]};
        if (x) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  task automatic expect_frame(input logic [7:0] body[$], input logic err, input string tag);
    foreach (body[k]) begin
      exp_t e;
      e.d = body[k];
      e.eof = (k == body.size() - 1);
      e.err = e.eof ? err : 1'b0;
      e.tag = tag;
      expq.push_back(e);
    end
  endtask

  task automatic send_frame(input logic [7:0] body[$], input bit good,
                            input bit deliver, input string tag);
    logic [15:0] f;
    f = tb_fcs(body);
    if (!good) f[0] = ~f[0];
    if (deliver) expect_frame(body, !good, tag);
    send_delim();
    foreach (body[k]) send_byte(body[k]);
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    send_delim();
  endtask

  task automatic drain(input string tag);
    repeat (6) @(negedge clk);
    check(expq.size() == 0, tag, "pending expected writes", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hunt_status === 1'b1, "R1", "hunt after reset", hunt_status, 1);
    check(wr_valid === 1'b0, "R1", "no write after reset", wr_valid, 0);
    rst_n = 1'b1;
    rx_enable = 1'b1;
    @(negedge clk);

    // R2: noise before the first delimiter writes nothing
    for (int i = 0; i < 16; i++) line_bit(i[0] ^ i[2]);
    run = 0;
    drain("R2");
    check(hunt_status === 1'b1, "R2", "still hunting", hunt_status, 1);

    // R5 R8 R9: good frame, search off
    send_delim();
    check(hunt_status === 1'b0, "R2", "hunt ends on delimiter", hunt_status, 0);
    send_frame('{8'h12, 8'h34, 8'h56, 8'h9A}, 1'b1, 1'b1, "R5");
    drain("R8");

    // R3: payload needing zero removal
    send_frame('{8'h7E, 8'hFF, 8'h1F, 8'hF8, 8'h3F}, 1'b1, 1'b1, "R3");
    drain("R3");

    // R9: corrupted check
    send_frame('{8'hC3, 8'h01, 8'h80}, 1'b0, 1'b1, "R9");
    drain("R9");

    // R6: full-address search
    addr_search_en = 1'b1;
    station_addr = 8'hA5;
    send_frame('{8'hA5, 8'h11, 8'h22}, 1'b1, 1'b1, "R6");
    drain("R6");
    send_frame('{8'hFF, 8'h33}, 1'b1, 1'b1, "R6");
    drain("R6");
    send_delim();
    send_byte(8'hA4);
    check(hunt_status === 1'b1, "R6", "mismatch returns to hunt", hunt_status, 1);
    send_byte(8'h44); send_byte(8'h55); send_byte(8'h66);
    send_delim();
    drain("R6");

    // R7: upper-nibble compare
    addr_nibble_only = 1'b1;
    send_frame('{8'hA3, 8'h77, 8'h88}, 1'b1, 1'b1, "R7");
    drain("R7");
    send_frame('{8'hB5, 8'h77}, 1'b1, 1'b0, "R7");
    drain("R7");
    addr_nibble_only = 1'b0;
    send_frame('{8'hA3, 8'h77}, 1'b1, 1'b0, "R7");
    drain("R7");
    addr_search_en = 1'b0;

    // R4: abort mid-frame
    expect_frame('{8'h21, 8'h31}, 1'b0, "R4");
    expq[expq.size()-1].eof = 1'b0;
    send_delim();
    send_byte(8'h21); send_byte(8'h31); send_byte(8'h41);
    send_byte(8'h51); send_byte(8'h61);
    send_abort();
    check(hunt_status === 1'b1, "R4", "hunt after abort", hunt_status, 1);
    send_byte(8'h13); send_byte(8'h24);
    drain("R4");

    // R10: frames too short for a check
    send_delim();
    expq.push_back('{8'h5A, 1'b1, 1'b1, "R10"});
    send_byte(8'h5A);
    send_delim();
    drain("R10");
    expq.push_back('{8'h6B, 1'b1, 1'b1, "R10"});
    send_byte(8'h6B); send_byte(8'h7C);
    send_delim();
    drain("R10");

    // R11: hunt command mid-frame
    send_delim();
    send_byte(8'h10); send_byte(8'h20);
    @(negedge clk); hunt_cmd = 1'b1;
    @(negedge clk); hunt_cmd = 1'b0;
    check(hunt_status === 1'b1, "R11", "hunt after command", hunt_status, 1);
    send_byte(8'h30); send_byte(8'h40); send_byte(8'h50);
    send_delim();
    drain("R11");

    // R1: disabled receiver ignores a complete frame
    rx_enable = 1'b0;
    @(negedge clk);
    send_frame('{8'h99, 8'hAA, 8'hBB}, 1'b1, 1'b0, "R1");
    check(hunt_status === 1'b1, "R1", "hunt while disabled", hunt_status, 1);
    drain("R1");
    rx_enable = 1'b1;
    @(negedge clk);

    // R5: receiver works again after re-enable
    send_frame('{8'h0F, 8'hF0}, 1'b1, 1'b1, "R5");
    drain("R5");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule